// File: doc/BRIEF.md
# Row Activation Hammer Detector

This block sits beside the DRAM command path on a passive tap. It sees every row-activate command, but it never holds up or changes that traffic, so read and write latency stay the same. For each activate it takes the bank and row and looks them up in a small table. The table holds only the most frequently activated rows in the current refresh window, not one counter per row of the device.

Each tracked row has its own activation counter. When a counter reaches a programmable threshold, the block reports that row as an aggressor. It does this with a one-cycle strobe that carries the row's bank and row. The row then stays flagged until the window ends.

When the table is full, a new row replaces the entry with the lowest count. The newcomer inherits that count plus one, so a heavily hammered row is never under-counted. A refresh-window tick empties the whole table in one cycle, so detection restarts every window. A mitigation engine elsewhere consumes the strobe.

Top module: `rowhammer_tracker`

## Requirements
- R1: While reset is held, and until the first activate after it, `hit_o` and `flag_vld_o` are 0, `flag_bank_o` and `flag_row_o` are 0, `flag_num_o` is 0 and the table is empty.
- R2: `hit_o` is 1 in the cycle after an activate whose {bank,row} pair matches a valid entry, and 0 otherwise. An activate of an untracked pair takes the lowest-numbered free entry with a count of 1.
- R3: The bank is part of the lookup key. The same row number in two banks occupies two separate entries with independent counts.
- R4: In the cycle after an activate lifts an entry's count to a value greater than or equal to `thresh_i`, `flag_vld_o` is 1 for one cycle, and `flag_bank_o`/`flag_row_o` carry that entry's pair. Each entry raises this strobe at most once per window.
- R5: Counts saturate at 2^CNT_W-1 and never wrap.
- R6: On a miss with every entry valid, the entry with the smallest count is replaced, the lowest index winning ties. The new pair starts at that smallest count plus one.
- R7: A window tick with no activate invalidates every entry and clears every count and flag. From the next cycle, `flag_num_o` is 0 and earlier rows miss.
- R8: An activate in the same cycle as a window tick is counted in the new window as its first activation (count 1, `hit_o` 0).
- R9: `flag_num_o` equals the number of entries flagged in the current window.
- R10: The threshold comparison is made only when an entry is updated. Lowering `thresh_i` flags no entry until that entry's next activate.
- R11: `flag_bank_o` and `flag_row_o` hold the pair of the last strobe until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| act_i | input | 1 | Row-activate command seen on the tap |
| bank_i | input | BANK_W | Bank of the activate |
| row_i | input | ROW_W | Row of the activate |
| win_tick_i | input | 1 | Refresh-window boundary; clears the table |
| thresh_i | input | CNT_W | Aggressor threshold |
| hit_o | output | 1 | Previous activate matched a tracked entry |
| flag_vld_o | output | 1 | One-cycle aggressor report strobe |
| flag_bank_o | output | BANK_W | Bank of the last reported aggressor |
| flag_row_o | output | ROW_W | Row of the last reported aggressor |
| flag_num_o | output | $clog2(ENTRIES+1) | Entries flagged in the current window |

## Verification
The hardest situations to reach from the ports are eviction from a full table and counter saturation, because no port shows a count. The bench builds a full table with a chosen spread of counts and forces a miss. It then tells which entry was evicted by whether later activates of the old pairs hit or miss. It infers the inherited count from the activate on which a lowered threshold first fires. Saturation is exposed by hammering one row past the counter maximum and then forcing an eviction: a wrapped count would make that row the victim.

// File: rtl/rht_pkg.sv
package rht_pkg;

  typedef enum logic [1:0] {
    UPD_IDLE  = 2'd0,
    UPD_HIT   = 2'd1,
    UPD_FILL  = 2'd2,
    UPD_EVICT = 2'd3
  } upd_e;

endpackage

// File: rtl/rht_match.sv
module rht_match #(
  parameter int N      = 16,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 16,
  parameter int IDX_W  = 4
) (
  input  logic [N-1:0]             vld,
  input  logic [N-1:0][BANK_W-1:0] ent_bank,
  input  logic [N-1:0][ROW_W-1:0]  ent_row,
  input  logic [BANK_W-1:0]        q_bank,
  input  logic [ROW_W-1:0]         q_row,
  output logic                     hit,
  output logic [IDX_W-1:0]         hit_idx
);

  logic [N-1:0] eq;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = vld[g] && (ent_bank[g] == q_bank) && (ent_row[g] == q_row);
  end

  always_comb begin
    hit     = |eq;
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (eq[i]) hit_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/rht_victim.sv
module rht_victim #(
  parameter int N     = 16,
  parameter int CNT_W = 8,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]            vld,
  input  logic [N-1:0][CNT_W-1:0] cnt,
  output logic                    full,
  output logic [IDX_W-1:0]        free_idx,
  output logic [IDX_W-1:0]        min_idx,
  output logic [CNT_W-1:0]        min_cnt
);

  always_comb begin
    full     = &vld;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld[i]) free_idx = IDX_W'(i);
    end
    min_idx = '0;
    min_cnt = cnt[0];
    for (int i = 1; i < N; i++) begin
      if (cnt[i] < min_cnt) begin
        min_cnt = cnt[i];
        min_idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/rht_popcnt.sv
module rht_popcnt #(
  parameter int N     = 16,
  parameter int OUT_W = 5
) (
  input  logic [N-1:0]     bits,
  output logic [OUT_W-1:0] total
);

  always_comb begin
    total = '0;
    for (int i = 0; i < N; i++) begin
      total = total + OUT_W'(bits[i]);
    end
  end

endmodule

// File: rtl/rowhammer_tracker.sv
module rowhammer_tracker
  import rht_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int BANK_W  = 3,
  parameter int ROW_W   = 16,
  parameter int CNT_W   = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           act_i,
  input  logic [BANK_W-1:0]              bank_i,
  input  logic [ROW_W-1:0]               row_i,
  input  logic                           win_tick_i,
  input  logic [CNT_W-1:0]               thresh_i,
  output logic                           hit_o,
  output logic                           flag_vld_o,
  output logic [BANK_W-1:0]              flag_bank_o,
  output logic [ROW_W-1:0]               flag_row_o,
  output logic [$clog2(ENTRIES+1)-1:0]   flag_num_o
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int NUM_W = $clog2(ENTRIES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // reset synchronizer: assert asynchronously, release on clock
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  // table state
  logic [ENTRIES-1:0]             vld_q, vld_d, vld_eff;
  logic [ENTRIES-1:0]             flg_q, flg_d, flg_eff;
  logic [ENTRIES-1:0][CNT_W-1:0]  cnt_q, cnt_d, cnt_eff;
  logic [ENTRIES-1:0][BANK_W-1:0] bank_q, bank_d;
  logic [ENTRIES-1:0][ROW_W-1:0]  row_q, row_d;

  logic                hit_d, fvld_d;
  logic [BANK_W-1:0]   fbank_d;
  logic [ROW_W-1:0]    frow_d;

  logic                m_hit;
  logic [IDX_W-1:0]    m_idx;
  logic                v_full;
  logic [IDX_W-1:0]    v_free, v_min;
  logic [CNT_W-1:0]    v_mincnt;

  upd_e                upd;
  logic [IDX_W-1:0]    widx;
  logic [CNT_W-1:0]    base, newcnt;
  logic                over, raise;
  logic                tbl_en;

  // a window tick empties the table before this cycle's activate is seen
  assign vld_eff = win_tick_i ? '0 : vld_q;
  assign flg_eff = win_tick_i ? '0 : flg_q;
  assign cnt_eff = win_tick_i ? '0 : cnt_q;

  rht_match #(
    .N(ENTRIES), .BANK_W(BANK_W), .ROW_W(ROW_W), .IDX_W(IDX_W)
  ) u_match (
    .vld(vld_eff), .ent_bank(bank_q), .ent_row(row_q),
    .q_bank(bank_i), .q_row(row_i),
    .hit(m_hit), .hit_idx(m_idx)
  );

  rht_victim #(
    .N(ENTRIES), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_victim (
    .vld(vld_eff), .cnt(cnt_eff),
    .full(v_full), .free_idx(v_free), .min_idx(v_min), .min_cnt(v_mincnt)
  );

  rht_popcnt #(
    .N(ENTRIES), .OUT_W(NUM_W)
  ) u_pop (
    .bits(flg_q), .total(flag_num_o)
  );

  // next-state logic
  always_comb begin
    vld_d  = vld_eff;
    flg_d  = flg_eff;
    cnt_d  = cnt_eff;
    bank_d = bank_q;
    row_d  = row_q;
    upd    = UPD_IDLE;
    widx   = '0;
    base   = '0;
    newcnt = '0;
    over   = 1'b0;
    raise  = 1'b0;
    if (act_i) begin
      if (m_hit) begin
        upd  = UPD_HIT;
        widx = m_idx;
        base = cnt_eff[m_idx];
      end else if (!v_full) begin
        upd  = UPD_FILL;
        widx = v_free;
        base = '0;
      end else begin
        upd  = UPD_EVICT;
        widx = v_min;
        base = v_mincnt;
      end
      newcnt = (base == CNT_MAX) ? base : base + CNT_W'(1);
      over   = (newcnt >= thresh_i);
      case (upd)
        UPD_HIT: begin
          raise       = over && !flg_eff[widx];
          flg_d[widx] = flg_eff[widx] | over;
        end
        UPD_FILL: begin
          raise       = over;
          flg_d[widx] = over;
        end
        UPD_EVICT: begin
          // a flagged slot keeps its flag; the incoming pair is reported
          raise       = over || flg_eff[widx];
          flg_d[widx] = raise;
        end
        default: raise = 1'b0;
      endcase
      vld_d[widx] = 1'b1;
      cnt_d[widx] = newcnt;
      if (upd != UPD_HIT) begin
        bank_d[widx] = bank_i;
        row_d[widx]  = row_i;
      end
    end
    tbl_en  = act_i | win_tick_i;
    hit_d   = (upd == UPD_HIT);
    fvld_d  = raise;
    fbank_d = bank_i;
    frow_d  = row_i;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q       <= '0;
      flg_q       <= '0;
      cnt_q       <= '0;
      bank_q      <= '0;
      row_q       <= '0;
      hit_o       <= 1'b0;
      flag_vld_o  <= 1'b0;
      flag_bank_o <= '0;
      flag_row_o  <= '0;
    end else begin
      if (tbl_en) begin
        vld_q  <= vld_d;
        flg_q  <= flg_d;
        cnt_q  <= cnt_d;
        bank_q <= bank_d;
        row_q  <= row_d;
      end
      hit_o      <= hit_d;
      flag_vld_o <= fvld_d;
      if (fvld_d) begin
        flag_bank_o <= fbank_d;
        flag_row_o  <= frow_d;
      end
    end
  end

endmodule

// File: rtl/rht_checker.sv
module rht_checker #(
  parameter int ENTRIES = 16,
  parameter int BANK_W  = 3,
  parameter int ROW_W   = 16,
  parameter int NUM_W   = 5
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              act_i,
  input logic              win_tick_i,
  input logic              hit_o,
  input logic              flag_vld_o,
  input logic [BANK_W-1:0] flag_bank_o,
  input logic [ROW_W-1:0]  flag_row_o,
  input logic [NUM_W-1:0]  flag_num_o
);

  a_r2_hit_needs_act: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hit_o |-> $past(act_i));

  a_r4_strobe_needs_act: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flag_vld_o |-> $past(act_i));

  a_r4_strobe_counted: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flag_vld_o |-> (flag_num_o != '0));

  a_r7_tick_clears: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (win_tick_i && !act_i) |=> (flag_num_o == '0) && !hit_o && !flag_vld_o);

  a_r8_tick_act_fresh: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (win_tick_i && act_i) |=> !hit_o && (flag_num_o <= NUM_W'(1)));

  a_r9_num_bound: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flag_num_o <= NUM_W'(ENTRIES));

  a_r9_num_monotone: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !win_tick_i |=> (flag_num_o >= $past(flag_num_o)));

  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!win_tick_i && !act_i) |=> $stable(flag_num_o));

  a_r11_hold_pair: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !flag_vld_o |-> ($stable(flag_bank_o) && $stable(flag_row_o)));

endmodule

bind rowhammer_tracker rht_checker #(
  .ENTRIES(ENTRIES), .BANK_W(BANK_W), .ROW_W(ROW_W), .NUM_W(NUM_W)
) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .act_i(act_i), .win_tick_i(win_tick_i),
  .hit_o(hit_o), .flag_vld_o(flag_vld_o), .flag_bank_o(flag_bank_o),
  .flag_row_o(flag_row_o), .flag_num_o(flag_num_o)
);

// File: tb/rowhammer_tracker_test.sv
module rowhammer_tracker_test;

  localparam int ENTRIES = 16;
  localparam int BANK_W  = 3;
  localparam int ROW_W   = 16;
  localparam int CNT_W   = 4;
  localparam int NUM_W   = 5;

  logic              clk;
  logic              rst_n;
  logic              act;
  logic [BANK_W-1:0] bank;
  logic [ROW_W-1:0]  row;
  logic              win_tick;
  logic [CNT_W-1:0]  thresh;
  logic              hit;
  logic              fvld;
  logic [BANK_W-1:0] fbank;
  logic [ROW_W-1:0]  frow;
  logic [NUM_W-1:0]  fnum;

  int nchk = 0;
  int nbad = 0;
  bit done = 0;

  rowhammer_tracker #(
    .ENTRIES(ENTRIES), .BANK_W(BANK_W), .ROW_W(ROW_W), .CNT_W(CNT_W)
  ) uut (
    .clk(clk), .rst_n(rst_n), .act_i(act), .bank_i(bank), .row_i(row),
    .win_tick_i(win_tick), .thresh_i(thresh), .hit_o(hit),
    .flag_vld_o(fvld), .flag_bank_o(fbank), .flag_row_o(frow),
    .flag_num_o(fnum)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic              tick;
    logic              act;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [CNT_W-1:0]  thr;
    logic              ehit;
    logic              evld;
    logic [BANK_W-1:0] ebank;
    logic [ROW_W-1:0]  erow;
    logic [NUM_W-1:0]  enum_f;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b0, 1'b1, 3'd1, 16'd100, 4'd3, 1'b0, 1'b0, 3'd0, 16'd0,   5'd0},
    '{1'b0, 1'b1, 3'd1, 16'd100, 4'd3, 1'b1, 1'b0, 3'd0, 16'd0,   5'd0},
    '{1'b0, 1'b1, 3'd2, 16'd100, 4'd3, 1'b0, 1'b0, 3'd0, 16'd0,   5'd0},
    '{1'b0, 1'b1, 3'd1, 16'd100, 4'd3, 1'b1, 1'b1, 3'd1, 16'd100, 5'd1},
    '{1'b0, 1'b1, 3'd1, 16'd100, 4'd3, 1'b1, 1'b0, 3'd1, 16'd100, 5'd1},
    '{1'b0, 1'b0, 3'd0, 16'd0,   4'd3, 1'b0, 1'b0, 3'd1, 16'd100, 5'd1},
    '{1'b0, 1'b1, 3'd2, 16'd100, 4'd3, 1'b1, 1'b0, 3'd1, 16'd100, 5'd1},
    '{1'b0, 1'b1, 3'd2, 16'd100, 4'd3, 1'b1, 1'b1, 3'd2, 16'd100, 5'd2},
    '{1'b1, 1'b0, 3'd0, 16'd0,   4'd3, 1'b0, 1'b0, 3'd2, 16'd100, 5'd0},
    '{1'b0, 1'b1, 3'd1, 16'd100, 4'd3, 1'b0, 1'b0, 3'd2, 16'd100, 5'd0},
    '{1'b1, 1'b1, 3'd3, 16'd7,   4'd3, 1'b0, 1'b0, 3'd2, 16'd100, 5'd0},
    '{1'b0, 1'b1, 3'd3, 16'd7,   4'd3, 1'b1, 1'b0, 3'd2, 16'd100, 5'd0},
    '{1'b0, 1'b1, 3'd3, 16'd7,   4'd3, 1'b1, 1'b1, 3'd3, 16'd7,   5'd1},
    '{1'b0, 1'b1, 3'd1, 16'd100, 4'd3, 1'b0, 1'b0, 3'd3, 16'd7,   5'd1}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic step(input logic t, input logic a, input logic [BANK_W-1:0] b,
                      input logic [ROW_W-1:0] r);
    @(negedge clk);
    win_tick = t;
    act      = a;
    bank     = b;
    row      = r;
    @(posedge clk);
    #1;
    win_tick = 1'b0;
    act      = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int flags;
    rst_n = 1'b0; act = 1'b0; win_tick = 1'b0; bank = '0; row = '0; thresh = 4'd3;
    repeat (3) @(posedge clk);
    // R1: values while reset is held
    #1;
    chk("R1 hit in reset", 32'(hit), 0);
    chk("R1 strobe in reset", 32'(fvld), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 hit after reset", 32'(hit), 0);
    chk("R1 strobe after reset", 32'(fvld), 0);
    chk("R1 bank after reset", 32'(fbank), 0);
    chk("R1 row after reset", 32'(frow), 0);
    chk("R1 count after reset", 32'(fnum), 0);

    // table walk: R2 R3 R4 R7 R8 R9 R11
    for (int i = 0; i < NV; i++) begin
      thresh = VEC[i].thr;
      step(VEC[i].tick, VEC[i].act, VEC[i].bank, VEC[i].row);
      chk($sformatf("R2/R3 hit vec %0d", i), 32'(hit), 32'(VEC[i].ehit));
      chk($sformatf("R4 strobe vec %0d", i), 32'(fvld), 32'(VEC[i].evld));
      chk($sformatf("R11 bank vec %0d", i), 32'(fbank), 32'(VEC[i].ebank));
      chk($sformatf("R11 row vec %0d", i), 32'(frow), 32'(VEC[i].erow));
      chk($sformatf("R7/R8/R9 count vec %0d", i), 32'(fnum), 32'(VEC[i].enum_f));
    end

    // R6: eviction of lowest count, lowest index on ties, inherit min+1
    thresh = 4'd15;
    step(1'b1, 1'b0, '0, '0);
    for (int r = 0; r < 16; r++) step(1'b0, 1'b1, 3'd0, 16'(r));
    for (int r = 0; r < 16; r++) if (r != 3 && r != 5) step(1'b0, 1'b1, 3'd0, 16'(r));
    step(1'b0, 1'b1, 3'd0, 16'd500);
    chk("R6 new pair misses", 32'(hit), 0);
    step(1'b0, 1'b1, 3'd0, 16'd3);
    chk("R6 lowest-index min victim gone", 32'(hit), 0);
    step(1'b0, 1'b1, 3'd0, 16'd4);
    chk("R6 non-victim still tracked", 32'(hit), 1);
    // R10: lowering the threshold flags nothing by itself
    thresh = 4'd3;
    step(1'b0, 1'b0, '0, '0);
    chk("R10 no flag without update", 32'(fnum), 0);
    step(1'b0, 1'b1, 3'd0, 16'd500);
    chk("R6 inherited count reaches 3", 32'(fvld), 1);
    chk("R6 strobe row", 32'(frow), 500);
    chk("R9 one flagged", 32'(fnum), 1);
    step(1'b0, 1'b1, 3'd0, 16'd3);
    chk("R6 re-entered pair inherited 2", 32'(fvld), 1);
    chk("R9 two flagged", 32'(fnum), 2);

    // R5: saturation keeps a hammered row from becoming the victim
    thresh = 4'd15;
    step(1'b1, 1'b0, '0, '0);
    flags = 0;
    for (int k = 0; k < 20; k++) begin
      step(1'b0, 1'b1, 3'd1, 16'd9);
      if (fvld) flags++;
      if (k == 14) chk("R4 strobe at threshold", 32'(fvld), 1);
    end
    chk("R4 single strobe per window", 32'(flags), 1);
    for (int r = 20; r < 35; r++)
      for (int k = 0; k < 5; k++) step(1'b0, 1'b1, 3'd0, 16'(r));
    step(1'b0, 1'b1, 3'd0, 16'd99);
    chk("R6 evicting miss", 32'(hit), 0);
    step(1'b0, 1'b1, 3'd1, 16'd9);
    chk("R5 saturated row survives eviction", 32'(hit), 1);
    chk("R5 no second strobe", 32'(fvld), 0);
    chk("R9 count after saturation", 32'(fnum), 1);
    step(1'b0, 1'b1, 3'd0, 16'd20);
    chk("R6 first min entry was replaced", 32'(hit), 0);

    // R7: tick clears previous tracking
    step(1'b1, 1'b0, '0, '0);
    chk("R7 count cleared", 32'(fnum), 0);
    step(1'b0, 1'b1, 3'd1, 16'd9);
    chk("R7 old row misses", 32'(hit), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule